// File: doc/BRIEF.md
# AES Key Expansion Assist Unit

This block computes the substituted and rotated words that an AES key schedule needs, but it does not build the round key itself. A request carries a 128-bit source value and an 8-bit round constant. The source is split into four 32-bit words. The block runs the AES forward S-box over the two odd-numbered words, then returns each substituted word twice: once plain, and once rotated by one byte and mixed with the round constant. Both even-numbered words are discarded.

The last XOR, which chains this result with earlier key words, is left to the surrounding logic. That is why one unit can serve 128-, 192- and 256-bit key schedules. Requests and responses use a valid/ready handshake. The pipeline has two stages. It accepts one request per cycle and stalls as a whole when the response side is not ready.

Top module: `aes_kga_top`

## Requirements
- R1: The source is split into X0=src[31:0], X1=src[63:32], X2=src[95:64] and X3=src[127:96]. dst[31:0] equals SubWord(X1), with no rotation and no constant.
- R2: dst[63:32] equals RotWord(SubWord(X1)) XOR RCON. RotWord maps a word with bytes {b3,b2,b1,b0} (b0 in bits 7:0) to {b0,b3,b2,b1}.
- R3: dst[95:64] equals SubWord(X3), with no rotation and no constant.
- R4: dst[127:96] equals RotWord(SubWord(X3)) XOR RCON.
- R5: RCON is imm8 zero-extended to 32 bits. Only bits 7:0 of the two constant-mixed words differ from the rotated substituted words.
- R6: X0 and X2 have no effect on dst.
- R7: SubWord applies the standard AES forward S-box to each byte on its own. Examples: 0x00→0x63, 0x01→0x7c, 0x53→0xed.
- R8: out_valid is asserted exactly two cycles after an accepted request when the output side is ready. With out_ready held high, a new request is accepted every cycle.
- R9: While out_valid is high and out_ready is low, out_valid stays high and dst holds its value on the next cycle.
- R10: in_ready is high exactly when out_valid is low or out_ready is high.
- R11: A synchronous active-high rst empties the pipeline. On the cycle after rst, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| src | input | 128 | Source words X3..X0 |
| imm8 | input | 8 | Round constant byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream ready for result |
| dst | output | 128 | Assist result |

## Verification
Each result word comes from one byte lookup path, so an S-box fault shows up as a wrong byte in both a plain word and its rotated twin. The bench catches it on the first response that uses that byte value. A rotation or constant-mixing fault shows only in the odd words of dst, and it shows at once. A fault in a pipeline valid bit shows as one of three symptoms: a response arriving one cycle early or late, a dropped or duplicated response against the bench's queue, or dst changing during a stall. Each of these appears at the ports within two cycles of the request involved.

// File: rtl/aes_kga_pkg.sv
package aes_kga_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 4;
    localparam int DATA_W   = WORD_W * NWORDS;
    localparam int BPW      = WORD_W / BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0] data_t;

    // Multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ((sh << 1) ^ 8'h1b) : (sh << 1);
        end
        return acc;
    endfunction

    // Forward S-box: inverse by raising to 254, then the affine map
    function automatic byte_t sbox_fwd(input byte_t x);
        byte_t p;
        byte_t r;
        byte_t s;
        p = x;
        r = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        s = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
              ^ {r[3:0], r[7:4]} ^ 8'h63;
        return s;
    endfunction

    // Cyclic move of the low byte to the top: {b3,b2,b1,b0} -> {b0,b3,b2,b1}
    function automatic word_t rot_word(input word_t w);
        return {w[BYTE_W-1:0], w[WORD_W-1:BYTE_W]};
    endfunction

endpackage

// File: rtl/aes_kga_sbox.sv
module aes_kga_sbox
    import aes_kga_pkg::*;
(
    input  byte_t in_byte,
    output byte_t out_byte
);
    always_comb begin
        out_byte = sbox_fwd(in_byte);
    end
endmodule

// File: rtl/aes_kga_subword.sv
module aes_kga_subword
    import aes_kga_pkg::*;
(
    input  word_t w_in,
    output word_t w_out
);
    for (genvar g = 0; g < BPW; g++) begin : g_lane
        aes_kga_sbox u_sbox (
            .in_byte  (w_in[g*BYTE_W +: BYTE_W]),
            .out_byte (w_out[g*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/aes_kga_mix.sv
module aes_kga_mix
    import aes_kga_pkg::*;
(
    input  word_t sub_lo,
    input  word_t sub_hi,
    input  byte_t rc,
    output data_t mixed
);
    word_t rc_w;

    always_comb begin
        rc_w  = {{(WORD_W-BYTE_W){1'b0}}, rc};
        mixed = {rot_word(sub_hi) ^ rc_w, sub_hi,
                 rot_word(sub_lo) ^ rc_w, sub_lo};
    end
endmodule

// File: rtl/aes_kga_top.sv
module aes_kga_top
    import aes_kga_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   src,
    input  logic [BYTE_W-1:0]   imm8,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   dst
);
    typedef struct packed {
        logic  v1;
        word_t sub_lo;
        word_t sub_hi;
        byte_t rc;
        logic  v2;
        data_t res;
    } pipe_t;

    pipe_t p_d, p_q;
    word_t sw_lo, sw_hi;
    data_t mix_res;
    logic  adv;

    aes_kga_subword u_sub_lo (.w_in(src[WORD_W +: WORD_W]),   .w_out(sw_lo));
    aes_kga_subword u_sub_hi (.w_in(src[3*WORD_W +: WORD_W]), .w_out(sw_hi));

    aes_kga_mix u_mix (
        .sub_lo (p_q.sub_lo),
        .sub_hi (p_q.sub_hi),
        .rc     (p_q.rc),
        .mixed  (mix_res)
    );

    always_comb begin
        adv = !p_q.v2 || out_ready;
        p_d = p_q;
        if (adv) begin
            p_d.v1     = in_valid;
            p_d.sub_lo = sw_lo;
            p_d.sub_hi = sw_hi;
            p_d.rc     = imm8;
            p_d.v2     = p_q.v1;
            p_d.res    = mix_res;
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
        if (rst) begin
            p_q.v1 <= 1'b0;
            p_q.v2 <= 1'b0;
        end
    end

    assign in_ready  = adv;
    assign out_valid = p_q.v2;
    assign dst       = p_q.res;
endmodule

// File: rtl/aes_kga_chk.sv
module aes_kga_chk
    import aes_kga_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] dst
);
    logic [WORD_W-1:0] diff_lo, diff_hi;
    assign diff_lo = dst[63:32]  ^ {dst[7:0],   dst[31:8]};
    assign diff_hi = dst[127:96] ^ {dst[71:64], dst[95:72]};

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(dst)));

    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 in_ready |=> out_valid);

    a_r10_ready: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    a_r11_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    a_r5_rcon_width: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (diff_lo[31:8] == '0 && diff_hi[31:8] == '0));

    a_r2_same_rcon: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (diff_lo[7:0] == diff_hi[7:0]));
endmodule

bind aes_kga_top aes_kga_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dst       (dst)
);

// File: tb/tb_aes_kga_top.sv
module tb_aes_kga_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] src;
    logic [7:0]   imm8;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] dst;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] sb [256];

    always #5 clk = ~clk;

    aes_kga_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src(src), .imm8(imm8), .out_valid(out_valid), .out_ready(out_ready),
        .dst(dst)
    );

    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int k = 15; k >= 8; k--) if (prod[k]) prod = prod ^ (16'h11b << (k - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] s;
        for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        s = 8'h63;
        for (int k = 0; k < 5; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
        return s;
    endfunction

    function automatic logic [31:0] m_sub(logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    function automatic logic [31:0] m_rot(logic [31:0] w);
        return {w[7:0], w[31:24], w[23:16], w[15:8]};
    endfunction

    function automatic logic [127:0] m_model(logic [127:0] s, logic [7:0] rc);
        logic [31:0] a = m_sub(s[63:32]);
        logic [31:0] b = m_sub(s[127:96]);
        return {m_rot(b) ^ {24'h0, rc}, b, m_rot(a) ^ {24'h0, rc}, a};
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmp_words(logic [127:0] act, logic [127:0] exp);
        chk(act[31:0]   == exp[31:0],   "R1", 128'(act[31:0]),   128'(exp[31:0]));
        chk(act[63:32]  == exp[63:32],  "R2", 128'(act[63:32]),  128'(exp[63:32]));
        chk(act[95:64]  == exp[95:64],  "R3", 128'(act[95:64]),  128'(exp[95:64]));
        chk(act[127:96] == exp[127:96], "R4", 128'(act[127:96]), 128'(exp[127:96]));
    endtask

    // One isolated request, output side always ready; checks R8 timing
    task automatic run_one(logic [127:0] s, logic [7:0] rc, output logic [127:0] res);
        @(negedge clk);
        in_valid = 1'b1; src = s; imm8 = rc; out_ready = 1'b1;
        #1 chk(in_ready, "R10", 128'(in_ready), 128'(1));
        @(negedge clk);
        in_valid = 1'b0;
        #1 chk(!out_valid, "R8", 128'(out_valid), 128'(0));
        @(negedge clk);
        #1 chk(out_valid, "R8", 128'(out_valid), 128'(1));
        res = dst;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid, "R11", 128'(out_valid), 128'(0));
        chk(in_ready, "R11", 128'(in_ready), 128'(1));
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [127:0] r, r2, e;
        logic [127:0] expq[$];
        logic [127:0] prev_dst;
        bit prev_stall;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) sb[i] = m_sbox(8'(i));
        rst = 1'b1; in_valid = 1'b0; src = '0; imm8 = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid, "R11", 128'(out_valid), 128'(0));
        chk(in_ready, "R11", 128'(in_ready), 128'(1));

        // Known S-box values (R7) and the rotation/constant layout
        run_one({32'h00000053, 32'h0, 32'h53010000, 32'h0}, 8'h01, r);
        chk(r[31:0]   == 32'hed7c6363, "R7", 128'(r[31:0]),   128'(32'hed7c6363));
        chk(r[63:32]  == 32'h63ed7c62, "R2", 128'(r[63:32]),  128'(32'h63ed7c62));
        chk(r[95:64]  == 32'h636363ed, "R3", 128'(r[95:64]),  128'(32'h636363ed));
        chk(r[127:96] == 32'hed636362, "R4", 128'(r[127:96]), 128'(32'hed636362));

        // Constant at its widest (R5)
        run_one({$urandom, $urandom, $urandom, $urandom}, 8'hff, r);
        chk((r[63:32] ^ m_rot(r[31:0])) == 32'h000000ff, "R5",
            128'(r[63:32] ^ m_rot(r[31:0])), 128'(32'hff));
        chk((r[127:96] ^ m_rot(r[95:64])) == 32'h000000ff, "R5",
            128'(r[127:96] ^ m_rot(r[95:64])), 128'(32'hff));

        // Even words ignored (R6)
        run_one({32'h1234abcd, 32'h00000000, 32'h9e3779b9, 32'h00000000}, 8'h36, r);
        run_one({32'h1234abcd, 32'hffffffff, 32'h9e3779b9, 32'hdeadbeef}, 8'h36, r2);
        chk(r == r2, "R6", r2, r);
        cmp_words(r, m_model({32'h1234abcd, 32'h0, 32'h9e3779b9, 32'h0}, 8'h36));

        // Back-to-back throughput (R8)
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            in_valid = (i < 10); src = {4{32'(i * 32'h01010101)}}; imm8 = 8'(i); out_ready = 1'b1;
            #1;
            if (i < 10) chk(in_ready, "R8", 128'(in_ready), 128'(1));
            if (i >= 2) begin
                chk(out_valid, "R8", 128'(out_valid), 128'(1));
                cmp_words(dst, m_model({4{32'((i - 2) * 32'h01010101)}}, 8'(i - 2)));
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        // Reset while full and stalled (R11)
        in_valid = 1'b1; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        #1 chk(out_valid, "R9", 128'(out_valid), 128'(1));
        do_reset();

        // Random traffic with backpressure
        prev_stall = 0;
        prev_dst = '0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (prev_stall) begin
                chk(out_valid, "R9", 128'(out_valid), 128'(1));
                chk(dst == prev_dst, "R9", dst, prev_dst);
            end
            in_valid  = ($urandom % 4) != 0;
            src       = {$urandom, $urandom, $urandom, $urandom};
            imm8      = 8'($urandom);
            out_ready = ($urandom % 3) != 0;
            #1;
            chk(in_ready == (!out_valid || out_ready), "R10", 128'(in_ready),
                128'(!out_valid || out_ready));
            if (in_valid && in_ready) expq.push_back(m_model(src, imm8));
            if (out_valid && out_ready) begin
                if (expq.size() == 0) chk(0, "R8", dst, '0);
                else begin
                    e = expq.pop_front();
                    cmp_words(dst, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_dst = dst;
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        do_reset();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule